// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address. It keeps four 16-bit segment base registers: code, data, stack and extra. Software loads them through a simple write port. For each access, a select input names the segment to use. The base is scaled by sixteen, so every segment starts on a 16-byte boundary and spans at most 64 KB. The offset is then added, and the sum wraps inside the 1 MB space.

The block also models a time-multiplexed address bus, paced by a bus-state input.

- **First state of a bus cycle:** the full 20-bit address is captured and driven.
- **Later states:** the address is held, and address lines 17:16 carry a 2-bit code naming the segment used.

The same code can prefix the address to form a 22-bit extended address. This gives each segment register its own 1 MB window, 4 MB in total.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears all four segment registers and drives every output to zero.
- R2: When wr_en is high at a clock edge, wr_data is stored in the register chosen by wr_sel, with the encoding 00 = extra, 01 = stack, 10 = code, 11 = data. The other three registers keep their values.
- R3: At a clock edge where bus_tstate is 0 (the first state of a bus cycle), phys_addr and bus_ad both take the value (segment × 16 + offset) one cycle later. The segment is the register picked by seg_sel (same encoding as R2).
- R4: The sum wraps modulo 2^20. For example, a segment of FFFF with offset 0010 gives physical address 00000.
- R5: At a clock edge where bus_tstate is 0, seg_status takes the value of seg_sel.
- R6: At a clock edge where bus_tstate is not 0, bus_ad is loaded as follows:
  - bits 17:16 take seg_status;
  - every other bit takes the matching bit of phys_addr.
- R7: At edges where bus_tstate is not 0, phys_addr, seg_status and ext_addr hold. Changes on seg_sel, offset and ext_en in those states have no effect on them.
- R8: At a clock edge where bus_tstate is 0, ext_addr is loaded with:
  - {seg_sel, sum} when ext_en is high;
  - {00, sum} when ext_en is low.
- R9: When a register is written at the same edge that starts a bus cycle using it, the address is formed from the register's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment register to write (00 extra, 01 stack, 10 code, 11 data) |
| wr_data | input | 16 | Value to write |
| bus_tstate | input | 2 | Bus state counter; 0 marks the first state of a bus cycle |
| seg_sel | input | 2 | Segment used for the access |
| offset | input | 16 | Offset within the segment |
| ext_en | input | 1 | Enables the 22-bit extended address |
| phys_addr | output | 20 | Latched 20-bit physical address |
| seg_status | output | 2 | Code of the segment used by the current bus cycle |
| bus_ad | output | 20 | Time-multiplexed address lines |
| ext_addr | output | 22 | Extended address, status code on top |

## Verification
The properties assume that bus_tstate steps through its states and that a value of 0 marks a new bus cycle. They do not assume any order or length of the later states. They also assume reset is asserted from time zero, so the history that $past looks at is always valid.

The stimulus meets these assumptions by driving every input half a cycle away from the active edge. It runs bus cycles of one to four states, and it may also change seg_sel, offset and ext_en in the middle of a cycle to show they are ignored there. Register writes happen both between bus cycles and on the very edge that starts one.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned SEG_W   = 16;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned SHIFT_W = 4;
  localparam int unsigned N_SEG   = 4;
  localparam int unsigned SEL_W   = $clog2(N_SEG);
  localparam int unsigned PA_W    = SEG_W + SHIFT_W;
  localparam int unsigned EXT_W   = PA_W + SEL_W;
  localparam int unsigned STAT_LSB = 16;
  localparam int unsigned TS_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_id_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int unsigned SEG_W = seg_addr_pkg::SEG_W,
  parameter int unsigned N_SEG = seg_addr_pkg::N_SEG,
  localparam int unsigned SEL_W = $clog2(N_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data
);
  logic [SEG_W-1:0] bank [N_SEG];

  // One register per segment; a write lands at the edge, so a
  // read in the same cycle still returns the previous contents.
  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[i] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        bank[i] <= wr_data;
      end
    end
  end

  assign rd_data = bank[rd_sel];
endmodule

// File: rtl/seg_addr_sum.sv
module seg_addr_sum #(
  parameter int unsigned SEG_W   = seg_addr_pkg::SEG_W,
  parameter int unsigned OFF_W   = seg_addr_pkg::OFF_W,
  parameter int unsigned SHIFT_W = seg_addr_pkg::SHIFT_W,
  localparam int unsigned PA_W   = SEG_W + SHIFT_W
) (
  input  logic [SEG_W-1:0] base,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  sum
);
  logic [PA_W-1:0] base_scaled;
  logic [PA_W-1:0] off_ext;

  assign base_scaled = {base, {SHIFT_W{1'b0}}};

  if (OFF_W >= PA_W) begin : g_off_trunc
    assign off_ext = off[PA_W-1:0];
  end else begin : g_off_zext
    assign off_ext = {{(PA_W-OFF_W){1'b0}}, off};
  end

  // Carry out of the top bit is dropped: the space wraps.
  assign sum = base_scaled + off_ext;
endmodule

// File: rtl/seg_bus_stage.sv
module seg_bus_stage #(
  parameter int unsigned PA_W     = seg_addr_pkg::PA_W,
  parameter int unsigned SEL_W    = seg_addr_pkg::SEL_W,
  parameter int unsigned STAT_LSB = seg_addr_pkg::STAT_LSB,
  parameter int unsigned TS_W     = seg_addr_pkg::TS_W,
  localparam int unsigned EXT_W   = PA_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  tstate,
  input  logic [SEL_W-1:0] sel,
  input  logic [PA_W-1:0]  sum,
  input  logic             ext_en,
  output logic [PA_W-1:0]  phys_addr,
  output logic [SEL_W-1:0] seg_status,
  output logic [PA_W-1:0]  bus_ad,
  output logic [EXT_W-1:0] ext_addr
);
  logic            first_state;
  logic [PA_W-1:0] status_word;

  assign first_state = (tstate == '0);

  // Status lanes overwrite their address bits; all others pass.
  for (genvar b = 0; b < PA_W; b++) begin : g_lane
    if (b >= STAT_LSB && b < STAT_LSB + SEL_W) begin : g_stat
      assign status_word[b] = seg_status[b-STAT_LSB];
    end else begin : g_addr
      assign status_word[b] = phys_addr[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      seg_status <= '0;
      bus_ad     <= '0;
      ext_addr   <= '0;
    end else if (first_state) begin
      phys_addr  <= sum;
      seg_status <= sel;
      bus_ad     <= sum;
      ext_addr   <= ext_en ? {sel, sum} : {{SEL_W{1'b0}}, sum};
    end else begin
      bus_ad     <= status_word;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic [TS_W-1:0]   bus_tstate,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [OFF_W-1:0]  offset,
  input  logic              ext_en,
  output logic [PA_W-1:0]   phys_addr,
  output logic [SEL_W-1:0]  seg_status,
  output logic [PA_W-1:0]   bus_ad,
  output logic [EXT_W-1:0]  ext_addr
);
  logic [SEG_W-1:0] base;
  logic [PA_W-1:0]  sum;

  seg_regfile #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (seg_sel),
    .rd_data (base)
  );

  seg_addr_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W)) u_sum (
    .base (base),
    .off  (offset),
    .sum  (sum)
  );

  seg_bus_stage #(.PA_W(PA_W), .SEL_W(SEL_W), .STAT_LSB(STAT_LSB), .TS_W(TS_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .tstate     (bus_tstate),
    .sel        (seg_sel),
    .sum        (sum),
    .ext_en     (ext_en),
    .phys_addr  (phys_addr),
    .seg_status (seg_status),
    .bus_ad     (bus_ad),
    .ext_addr   (ext_addr)
  );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_addr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [TS_W-1:0]  bus_tstate,
  input logic [SEL_W-1:0] seg_sel,
  input logic             ext_en,
  input logic [PA_W-1:0]  phys_addr,
  input logic [SEL_W-1:0] seg_status,
  input logic [PA_W-1:0]  bus_ad,
  input logic [EXT_W-1:0] ext_addr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (phys_addr == '0 && seg_status == '0 && bus_ad == '0 && ext_addr == '0));

  p_addr_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_tstate == '0) |=> (bus_ad == phys_addr));

  p_status_code_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_tstate == '0) |=> (seg_status == $past(seg_sel)));

  p_status_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_tstate != '0) |=> (bus_ad[STAT_LSB+SEL_W-1:STAT_LSB] == seg_status
                            && bus_ad[STAT_LSB-1:0] == phys_addr[STAT_LSB-1:0]
                            && bus_ad[PA_W-1:STAT_LSB+SEL_W] == phys_addr[PA_W-1:STAT_LSB+SEL_W]));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_tstate != '0) |=> ($stable(phys_addr) && $stable(seg_status) && $stable(ext_addr)));

  p_ext_on_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_tstate == '0 && ext_en) |=> (ext_addr == {seg_status, phys_addr}));

  p_ext_off_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_tstate == '0 && !ext_en) |=> (ext_addr == {{SEL_W{1'b0}}, phys_addr}));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_tstate (bus_tstate),
  .seg_sel    (seg_sel),
  .ext_en     (ext_en),
  .phys_addr  (phys_addr),
  .seg_status (seg_status),
  .bus_ad     (bus_ad),
  .ext_addr   (ext_addr)
);

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  bus_tstate = '0;
  logic [1:0]  seg_sel = '0;
  logic [15:0] offset = '0;
  logic        ext_en = 1'b0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_status;
  logic [19:0] bus_ad;
  logic [21:0] ext_addr;

  always #2.5 clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bus_tstate(bus_tstate), .seg_sel(seg_sel), .offset(offset), .ext_en(ext_en),
    .phys_addr(phys_addr), .seg_status(seg_status), .bus_ad(bus_ad), .ext_addr(ext_addr)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Behavioural reference model
  int m_seg [4];
  int m_addr = 0, m_stat = 0, m_bus = 0, m_ext = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_seg[i] = 0;
      m_addr = 0; m_stat = 0; m_bus = 0; m_ext = 0;
    end else begin
      if (bus_tstate == 0) begin
        m_addr = (m_seg[seg_sel] * 16 + int'(offset)) % 1048576;
        m_stat = int'(seg_sel);
        m_bus  = m_addr;
        m_ext  = ext_en ? (m_stat * 1048576 + m_addr) : m_addr;
      end else begin
        m_bus = (m_addr % 65536) + m_stat * 65536 + (m_addr / 262144) * 262144;
      end
      if (wr_en) m_seg[wr_sel] = int'(wr_data);
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_tag, "phys_addr", int'(phys_addr), m_addr);
      chk(cur_tag, "seg_status", int'(seg_status), m_stat);
      chk(cur_tag, "bus_ad", int'(bus_ad), m_bus);
      chk(cur_tag, "ext_addr", int'(ext_addr), m_ext);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic write_seg(logic [1:0] s, logic [15:0] v);
    wr_en = 1'b1; wr_sel = s; wr_data = v; bus_tstate = 2'd1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One bus cycle: first state, then nlate later states with noisy inputs
  task automatic bus_cycle(logic [1:0] s, logic [15:0] off, logic ext, int nlate);
    bus_tstate = 2'd0; seg_sel = s; offset = off; ext_en = ext;
    @(negedge clk);
    for (int k = 0; k < nlate; k++) begin
      bus_tstate = 2'(k % 3 + 1);
      seg_sel = ~s; offset = ~off; ext_en = ~ext;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset phys_addr", int'(phys_addr), 0);
    chk("R1", "reset ext_addr", int'(ext_addr), 0);
    rst = 1'b0;

    cur_tag = "R2";
    write_seg(2'b10, 16'h1234);
    write_seg(2'b11, 16'hFFFF);
    write_seg(2'b01, 16'h0100);
    write_seg(2'b00, 16'hA000);

    cur_tag = "R3";
    bus_cycle(2'b10, 16'h0056, 1'b0, 3);
    chk("R3", "code seg address", int'(phys_addr), 32'h12396);
    bus_cycle(2'b01, 16'hFFFF, 1'b0, 2);
    bus_cycle(2'b00, 16'h0000, 1'b0, 0);
    chk("R2", "extra seg kept value", int'(phys_addr), 32'hA0000);

    cur_tag = "R4";
    bus_cycle(2'b11, 16'h0010, 1'b0, 0);
    chk("R4", "wrap FFFF:0010", int'(phys_addr), 0);
    bus_cycle(2'b11, 16'hFFFF, 1'b0, 1);

    cur_tag = "R6";
    bus_cycle(2'b01, 16'h0203, 1'b0, 3);
    chk("R6", "status lanes on bus", int'(bus_ad), 32'h11203);
    cur_tag = "R7";
    chk("R7", "address held", int'(phys_addr), 32'h01203);
    chk("R5", "status is stack", int'(seg_status), 1);

    cur_tag = "R8";
    bus_cycle(2'b11, 16'h0020, 1'b1, 2);
    chk("R8", "extended address", int'(ext_addr), 32'h300010);
    bus_cycle(2'b10, 16'h0001, 1'b0, 1);
    chk("R8", "extended off", int'(ext_addr), 32'h012341);

    cur_tag = "R9";
    wr_en = 1'b1; wr_sel = 2'b10; wr_data = 16'h2000;
    bus_tstate = 2'd0; seg_sel = 2'b10; offset = 16'h0000; ext_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9", "old code base used", int'(phys_addr), 32'h12340);
    bus_cycle(2'b10, 16'h0000, 1'b0, 0);
    chk("R9", "new code base next", int'(phys_addr), 32'h20000);

    cur_tag = "R3";
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0)
        write_seg(2'($urandom_range(0, 3)), 16'($urandom));
      bus_cycle(2'($urandom_range(0, 3)), 16'($urandom), 1'($urandom_range(0, 1)),
                $urandom_range(0, 3));
    end

    cur_tag = "R1";
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset again bus_ad", int'(bus_ad), 0);
    rst = 1'b0;
    bus_cycle(2'b11, 16'h0007, 1'b1, 0);
    chk("R1", "segments cleared", int'(ext_addr), 32'h300007);

    finish_run();
  end
endmodule